// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Controller

This block sits behind a synchronous serial receiver and turns its character stream into filled memory buffers. A small table of descriptors, kept in internal registers, tells it where each buffer lives and how it may be used. Each descriptor has three 16-bit words: a status/control word, a data length and a buffer pointer. Software prepares these words through a host port and marks each descriptor as empty. The controller then fills the descriptors in ring order. It writes every received byte to memory at the buffer pointer plus the current count.

Frames are bounded by start and end strobes from the receiver. A frame may span several buffers, because a buffer closes when it reaches a programmed byte limit and also when a character arrives with a parity error. When it closes a buffer, the controller writes the final byte count and a status word. The status word records the frame position and the error conditions seen. An event pulse is raised when the descriptor asks for one. In continuous mode a descriptor stays owned by the controller after it closes, so the same memory is refilled on the next pass round the ring. A descriptor still held by software makes the controller raise a busy event and discard the rest of the frame.

Top module: `rx_bd_ring`

## Requirements
- R1: After reset every descriptor word reads zero, and no memory write or event is produced.
- R2: Status bit positions, with bit 15 as the most significant: CD 0, OV 1, CR 2, PR 3, NO 4, DE 7, CM 9, F 10, L 11, I 12, W 13, E 15. Bits 14, 8, 6 and 5 always read zero, even after a host write of ones. Host word select: 0 is status, 1 is length, 2 is pointer.
- R3: A descriptor is used only while its E bit (15) is 1. A character that finds E=0 raises a one-cycle `evt_busy`, and the rest of that frame is discarded. The ring index does not move.
- R4: Each accepted character is written to memory at pointer plus the bytes already in the buffer. At close, the length word holds the byte count of that buffer.
- R5: After a descriptor with W (bit 13) set is closed, the next descriptor is index 0. Otherwise the next one is the following index, and the last index wraps to 0.
- R6: F (bit 10) is set only in the first buffer of a frame. L (bit 11) is set only in the buffer closed by the frame-end strobe.
- R7: Closing a descriptor whose I bit (12) is set produces a one-cycle `evt_rxb` pulse. Without I there is no pulse.
- R8: With CM (bit 9) set and no error, E stays 1 at close, and the buffer is written again from its start on the next visit. Any error bit clears E regardless of CM.
- R9: A character flagged with a parity error is stored as the last byte of the current buffer, which closes with PR (bit 3) set. Later characters of the frame go to a new buffer with F clear.
- R10: A strobe of overrun, carrier loss or clock-recovery error during the buffer sets OV (bit 1), CD (bit 0) or DE (bit 7). A bad check or a non-octet flag at frame end sets CR (bit 2) or NO (bit 4).
- R11: A buffer whose count reaches a non-zero `max_len` closes without L, and the frame continues in the next descriptor with F clear.
- R12: A host write to the descriptor being filled changes nothing while it is open. The value appears once that buffer is closed.
- R13: Characters that arrive outside a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_sof | input | 1 | Frame start strobe |
| rx_eof | input | 1 | Frame end strobe, on a cycle without a character |
| rx_par_err | input | 1 | Parity error on the current character |
| rx_crc_bad | input | 1 | Check sequence failed, valid with `rx_eof` |
| rx_odd_bits | input | 1 | Frame length not a multiple of eight bits, valid with `rx_eof` |
| rx_overrun | input | 1 | Receiver overrun strobe |
| rx_carrier_lost | input | 1 | Carrier loss strobe |
| rx_clk_err | input | 1 | Clock-recovery error strobe |
| max_len | input | 16 | Byte limit per buffer, 0 means no limit |
| host_wr | input | 1 | Host write strobe |
| host_idx | input | IDX_W | Descriptor index for host read and write |
| host_sel | input | 2 | Word select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected descriptor word |
| mem_we | output | 1 | Memory byte write |
| mem_addr | output | 16 | Memory byte address |
| mem_data | output | 8 | Memory byte data |
| evt_rxb | output | 1 | Buffer closed with I set |
| evt_busy | output | 1 | Descriptor not available |

## Verification
The bench builds the block with `NDESC` set to 4. With that size a single frame runs through the wrap descriptor and then meets a descriptor that software has not yet returned, so wrap and busy are covered back to back. The same size lets a continuous-mode descriptor be revisited after only three short frames, so the overwrite of its buffer can be seen. `max_len` is driven to 6, which splits an eight-byte frame across two descriptors.

// File: rtl/rxbd_pkg.sv
// Shared constants and types for the receive descriptor ring.
// Assumes status bits are counted with bit 0 as the least significant.
package rxbd_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    // status bit positions
    localparam int ST_CD = 0;
    localparam int ST_OV = 1;
    localparam int ST_CR = 2;
    localparam int ST_PR = 3;
    localparam int ST_NO = 4;
    localparam int ST_DE = 7;
    localparam int ST_CM = 9;
    localparam int ST_F  = 10;
    localparam int ST_L  = 11;
    localparam int ST_I  = 12;
    localparam int ST_W  = 13;
    localparam int ST_E  = 15;
    localparam logic [WORD_W-1:0] ST_RSV_MASK = 16'h4160;

    // host word select codes
    localparam logic [1:0] SEL_STAT = 2'd0;
    localparam logic [1:0] SEL_LEN  = 2'd1;
    localparam logic [1:0] SEL_PTR  = 2'd2;

    // control bits the filler needs from a descriptor
    typedef struct packed {
        logic e;
        logic w;
        logic i;
        logic cm;
    } desc_ctl_t;

    // error bits reported at close
    typedef struct packed {
        logic de;
        logic no;
        logic pr;
        logic cr;
        logic ov;
        logic cd;
    } rx_err_t;

    // assemble a closing status word, reserved bits left zero
    function automatic logic [WORD_W-1:0] pack_status(
        input logic e, input logic w, input logic i, input logic l,
        input logic f, input logic cm, input rx_err_t er);
        logic [WORD_W-1:0] s;
        s        = '0;
        s[ST_E]  = e;
        s[ST_W]  = w;
        s[ST_I]  = i;
        s[ST_L]  = l;
        s[ST_F]  = f;
        s[ST_CM] = cm;
        s[ST_DE] = er.de;
        s[ST_NO] = er.no;
        s[ST_PR] = er.pr;
        s[ST_CR] = er.cr;
        s[ST_OV] = er.ov;
        s[ST_CD] = er.cd;
        return s;
    endfunction
endpackage

// File: rtl/rxbd_table.sv
// Descriptor storage: status, length and pointer words for NDESC entries.
// Two writers: the filler (at buffer close) and the host. When both hit the
// same word in one cycle the host wins. Reserved status bits are never stored.
module rxbd_table
    import rxbd_pkg::*;
#(
    parameter int NDESC = 8,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_en,
    input  logic [IDX_W-1:0]  cw_idx,
    input  logic [WORD_W-1:0] cw_stat,
    input  logic [WORD_W-1:0] cw_len,
    input  logic              cw_ptr_en,
    input  logic [WORD_W-1:0] cw_ptr,
    input  logic              hw_en,
    input  logic [IDX_W-1:0]  hw_idx,
    input  logic [1:0]        hw_sel,
    input  logic [WORD_W-1:0] hw_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [1:0]        rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  ci_idx,
    output desc_ctl_t         ci_ctl,
    output logic [WORD_W-1:0] ci_ptr
);
    logic [WORD_W-1:0] stat_q [NDESC];
    logic [WORD_W-1:0] len_q  [NDESC];
    logic [WORD_W-1:0] ptr_q  [NDESC];

    // update each entry: filler close first, host write afterwards
    always_ff @(posedge clk) begin
        for (int k = 0; k < NDESC; k++) begin
            if (!rst_n) begin
                stat_q[k] <= '0;
                len_q[k]  <= '0;
                ptr_q[k]  <= '0;
            end else begin
                if (cw_en && cw_idx == IDX_W'(k)) begin
                    stat_q[k] <= cw_stat & ~ST_RSV_MASK;
                    len_q[k]  <= cw_len;
                    if (cw_ptr_en) ptr_q[k] <= cw_ptr;
                end
                if (hw_en && hw_idx == IDX_W'(k)) begin
                    case (hw_sel)
                        SEL_STAT: stat_q[k] <= hw_data & ~ST_RSV_MASK;
                        SEL_LEN:  len_q[k]  <= hw_data;
                        SEL_PTR:  ptr_q[k]  <= hw_data;
                        default:  ;
                    endcase
                end
            end
        end
    end

    // host read mux
    always_comb begin
        case (rd_sel)
            SEL_STAT: rd_data = stat_q[rd_idx];
            SEL_LEN:  rd_data = len_q[rd_idx];
            SEL_PTR:  rd_data = ptr_q[rd_idx];
            default:  rd_data = '0;
        endcase
    end

    // current-descriptor view for the filler
    always_comb begin
        ci_ctl.e  = stat_q[ci_idx][ST_E];
        ci_ctl.w  = stat_q[ci_idx][ST_W];
        ci_ctl.i  = stat_q[ci_idx][ST_I];
        ci_ctl.cm = stat_q[ci_idx][ST_CM];
        ci_ptr    = ptr_q[ci_idx];
    end

    // R2: reserved status bits never read back as one
    p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_STAT) |-> ((rd_data & ST_RSV_MASK) == '0));
endmodule

// File: rtl/rxbd_hold.sv
// Holds host writes aimed at the descriptor currently being filled.
// Assumes capture and flush never fall in the same cycle (the top routes a
// host write in the closing cycle straight to the table).
module rxbd_hold
    import rxbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [1:0]        cap_sel,
    input  logic [WORD_W-1:0] cap_data,
    input  logic              flush,
    output logic              pv_stat,
    output logic              pv_len,
    output logic              pv_ptr,
    output logic [WORD_W-1:0] p_stat,
    output logic [WORD_W-1:0] p_len,
    output logic [WORD_W-1:0] p_ptr
);
    // record deferred words, drop them once handed to the table
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            pv_stat <= 1'b0;
            pv_len  <= 1'b0;
            pv_ptr  <= 1'b0;
            p_stat  <= '0;
            p_len   <= '0;
            p_ptr   <= '0;
        end else if (cap_en) begin
            case (cap_sel)
                SEL_STAT: begin pv_stat <= 1'b1; p_stat <= cap_data; end
                SEL_LEN:  begin pv_len  <= 1'b1; p_len  <= cap_data; end
                SEL_PTR:  begin pv_ptr  <= 1'b1; p_ptr  <= cap_data; end
                default:  ;
            endcase
        end
    end

    // R12: a flush leaves nothing pending
    p_hold_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !(pv_stat || pv_len || pv_ptr));
endmodule

// File: rtl/rxbd_fill.sv
// Buffer filler: follows frame strobes, opens descriptors in ring order,
// stores bytes, and decides when and how a buffer closes.
// Assumes rx_eof never coincides with rx_valid, and rx_sof arrives outside
// a frame (a start strobe inside a frame is ignored).
module rxbd_fill
    import rxbd_pkg::*;
#(
    parameter int NDESC = 8,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_par_err,
    input  logic              rx_crc_bad,
    input  logic              rx_odd_bits,
    input  logic              rx_overrun,
    input  logic              rx_carrier_lost,
    input  logic              rx_clk_err,
    input  logic [WORD_W-1:0] max_len,
    input  desc_ctl_t         ci_ctl,
    input  logic [WORD_W-1:0] ci_ptr,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              open_act,
    output logic              close,
    output logic [WORD_W-1:0] close_stat,
    output logic [WORD_W-1:0] close_len,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_data,
    output logic              evt_rxb,
    output logic              evt_busy
);
    logic              in_frame_q, open_q, drop_q, next_first_q, first_q;
    desc_ctl_t         ctl_q;
    logic [WORD_W-1:0] ptr_q, len_q;
    logic [IDX_W-1:0]  idx_q;
    logic              ov_q, cd_q, de_q;

    logic              take, need_open, opening, busy, wr, frame_end;
    desc_ctl_t         ctl_eff;
    logic [WORD_W-1:0] ptr_eff, len_base, len_new;
    logic              first_eff, ov_now, cd_now, de_now;
    logic              close_par, close_max, close_eof, has_err;
    rx_err_t           er;
    logic [IDX_W-1:0]  idx_next;

    assign cur_idx = idx_q;

    // acceptance and open decision for the incoming character
    always_comb begin
        take      = rx_valid && in_frame_q && !drop_q;
        need_open = take && !open_q;
        opening   = need_open && ci_ctl.e;
        busy      = need_open && !ci_ctl.e;
        wr        = take && (open_q || ci_ctl.e);
        frame_end = rx_eof && in_frame_q && !rx_valid;
        open_act  = open_q || opening;
    end

    // working view: registered copy once open, live table on the opening cycle
    always_comb begin
        ctl_eff   = open_q ? ctl_q   : ci_ctl;
        ptr_eff   = open_q ? ptr_q   : ci_ptr;
        first_eff = open_q ? first_q : next_first_q;
        len_base  = open_q ? len_q   : '0;
        len_new   = len_base + WORD_W'(1);
    end

    // sticky line errors including strobes of this cycle
    always_comb begin
        ov_now = ov_q || (in_frame_q && rx_overrun);
        cd_now = cd_q || (in_frame_q && rx_carrier_lost);
        de_now = de_q || (in_frame_q && rx_clk_err);
    end

    // close causes and the closing status word
    always_comb begin
        close_par = wr && rx_par_err;
        close_max = wr && !rx_par_err && (max_len != '0) && (len_new == max_len);
        close_eof = frame_end && open_q;
        close     = close_par || close_max || close_eof;
        er.de     = de_now;
        er.no     = close_eof && rx_odd_bits;
        er.pr     = close_par;
        er.cr     = close_eof && rx_crc_bad;
        er.ov     = ov_now;
        er.cd     = cd_now;
        has_err   = |er;
        close_stat = pack_status(ctl_eff.cm && !has_err, ctl_eff.w, ctl_eff.i,
                                 close_eof, first_eff, ctl_eff.cm, er);
        close_len  = close_eof ? len_q : len_new;
        idx_next   = (ctl_eff.w || idx_q == IDX_W'(NDESC - 1)) ? '0 : idx_q + IDX_W'(1);
    end

    // frame, buffer and ring state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q   <= 1'b0;
            open_q       <= 1'b0;
            drop_q       <= 1'b0;
            next_first_q <= 1'b0;
            first_q      <= 1'b0;
            ctl_q        <= '0;
            ptr_q        <= '0;
            len_q        <= '0;
            idx_q        <= '0;
            ov_q         <= 1'b0;
            cd_q         <= 1'b0;
            de_q         <= 1'b0;
        end else begin
            if (rx_sof && !in_frame_q) begin
                in_frame_q   <= 1'b1;
                next_first_q <= 1'b1;
                drop_q       <= 1'b0;
            end else if (frame_end) begin
                in_frame_q <= 1'b0;
                drop_q     <= 1'b0;
            end else if (busy) begin
                drop_q <= 1'b1;
            end
            if (opening) begin
                ctl_q        <= ci_ctl;
                ptr_q        <= ci_ptr;
                first_q      <= next_first_q;
                next_first_q <= 1'b0;
            end
            if (wr) len_q <= len_new;
            if (close) begin
                open_q <= 1'b0;
                idx_q  <= idx_next;
            end else if (opening) begin
                open_q <= 1'b1;
            end
            if (close || frame_end) begin
                ov_q <= 1'b0;
                cd_q <= 1'b0;
                de_q <= 1'b0;
            end else begin
                ov_q <= ov_now;
                cd_q <= cd_now;
                de_q <= de_now;
            end
        end
    end

    // memory store and event outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            evt_rxb  <= 1'b0;
            evt_busy <= 1'b0;
        end else begin
            mem_we   <= wr;
            if (wr) begin
                mem_addr <= ptr_eff + len_base;
                mem_data <= rx_data;
            end
            evt_rxb  <= close && ctl_eff.i;
            evt_busy <= busy;
        end
    end

    // R3: discarding frames never coexists with an open buffer
    p_drop_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drop_q |-> !open_q);
    // R3: at most one busy event per frame
    p_busy_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_busy |=> !evt_busy);
    // R5: wrap descriptor returns the ring to index 0
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (close && ctl_eff.w) |=> (idx_q == '0));
    // R5: otherwise the ring steps by one
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (close && !ctl_eff.w && idx_q != IDX_W'(NDESC - 1))
            |=> (idx_q == $past(idx_q) + IDX_W'(1)));
    // R13: characters outside a frame never reach memory
    p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !in_frame_q) |=> !mem_we);
    // R7: the close event follows a closed buffer
    p_rxb_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rxb |-> !open_q);
endmodule

// File: rtl/rx_bd_ring.sv
// Receive buffer descriptor ring controller, top level.
// Connects the filler, the descriptor table and the deferred host-write holder.
// Assumes one host access per cycle; reads are combinational from the table.
module rx_bd_ring
    import rxbd_pkg::*;
#(
    parameter int NDESC = 8,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_par_err,
    input  logic              rx_crc_bad,
    input  logic              rx_odd_bits,
    input  logic              rx_overrun,
    input  logic              rx_carrier_lost,
    input  logic              rx_clk_err,
    input  logic [WORD_W-1:0] max_len,
    input  logic              host_wr,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [1:0]        host_sel,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_data,
    output logic              evt_rxb,
    output logic              evt_busy
);
    desc_ctl_t         ci_ctl;
    logic [WORD_W-1:0] ci_ptr;
    logic [IDX_W-1:0]  cur_idx;
    logic              open_act, close;
    logic [WORD_W-1:0] close_stat, close_len;
    logic              hold_hit;
    logic              pv_stat, pv_len, pv_ptr;
    logic [WORD_W-1:0] p_stat, p_len, p_ptr;
    logic [WORD_W-1:0] cw_stat, cw_len;

    // a host write to the open descriptor waits unless it closes now
    always_comb begin
        hold_hit = host_wr && open_act && (host_idx == cur_idx) && !close;
        cw_stat  = pv_stat ? p_stat : close_stat;
        cw_len   = pv_len  ? p_len  : close_len;
    end

    rxbd_fill #(.NDESC(NDESC)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_par_err(rx_par_err), .rx_crc_bad(rx_crc_bad), .rx_odd_bits(rx_odd_bits),
        .rx_overrun(rx_overrun), .rx_carrier_lost(rx_carrier_lost),
        .rx_clk_err(rx_clk_err), .max_len(max_len),
        .ci_ctl(ci_ctl), .ci_ptr(ci_ptr),
        .cur_idx(cur_idx), .open_act(open_act), .close(close),
        .close_stat(close_stat), .close_len(close_len),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .evt_rxb(evt_rxb), .evt_busy(evt_busy)
    );

    rxbd_table #(.NDESC(NDESC)) u_table (
        .clk(clk), .rst_n(rst_n),
        .cw_en(close), .cw_idx(cur_idx), .cw_stat(cw_stat), .cw_len(cw_len),
        .cw_ptr_en(close && pv_ptr), .cw_ptr(p_ptr),
        .hw_en(host_wr && !hold_hit), .hw_idx(host_idx), .hw_sel(host_sel),
        .hw_data(host_wdata),
        .rd_idx(host_idx), .rd_sel(host_sel), .rd_data(host_rdata),
        .ci_idx(cur_idx), .ci_ctl(ci_ctl), .ci_ptr(ci_ptr)
    );

    rxbd_hold u_hold (
        .clk(clk), .rst_n(rst_n),
        .cap_en(hold_hit), .cap_sel(host_sel), .cap_data(host_wdata),
        .flush(close),
        .pv_stat(pv_stat), .pv_len(pv_len), .pv_ptr(pv_ptr),
        .p_stat(p_stat), .p_len(p_len), .p_ptr(p_ptr)
    );
endmodule

// File: tb/tb_rx_bd_ring.sv
module tb_rx_bd_ring;
    localparam int ND = 4;
    localparam int IW = 2;

    logic        clk, rst_n;
    logic        rx_valid, rx_sof, rx_eof, rx_par_err, rx_crc_bad, rx_odd_bits;
    logic        rx_overrun, rx_carrier_lost, rx_clk_err;
    logic [7:0]  rx_data;
    logic [15:0] max_len;
    logic        host_wr;
    logic [IW-1:0] host_idx;
    logic [1:0]  host_sel;
    logic [15:0] host_wdata, host_rdata;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic        evt_rxb, evt_busy;

    rx_bd_ring #(.NDESC(ND)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_par_err(rx_par_err),
        .rx_crc_bad(rx_crc_bad), .rx_odd_bits(rx_odd_bits), .rx_overrun(rx_overrun),
        .rx_carrier_lost(rx_carrier_lost), .rx_clk_err(rx_clk_err), .max_len(max_len),
        .host_wr(host_wr), .host_idx(host_idx), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .evt_rxb(evt_rxb), .evt_busy(evt_busy)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    typedef struct { int addr; int data; } wr_t;
    wr_t   exp_q[$];
    int    checks = 0, errors = 0, n_rxb = 0, n_busy = 0;
    string cur_req = "R1";

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each store, counts events
    always @(negedge clk) begin
        if (rst_n) begin
            if (evt_rxb)  n_rxb++;
            if (evt_busy) n_busy++;
            if (mem_we) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL %s: unexpected store addr %h data %h, expected none",
                             cur_req, mem_addr, mem_data);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    if (int'(mem_addr) != e.addr || int'(mem_data) != e.data) begin
                        errors++;
                        $display("FAIL %s: store actual %h/%h expected %h/%h",
                                 cur_req, mem_addr, mem_data, e.addr, e.data);
                    end
                end
            end
        end
    end

    // driver tasks
    task automatic send_char(input logic [7:0] d, input bit par, input int addr);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_par_err = par;
        if (addr >= 0) exp_q.push_back('{addr, int'(d)});
        @(negedge clk);
        rx_valid = 1'b0; rx_par_err = 1'b0;
    endtask

    task automatic send_sof();
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0;
    endtask

    task automatic send_eof(input bit crc, input bit odd);
        @(negedge clk); rx_eof = 1'b1; rx_crc_bad = crc; rx_odd_bits = odd;
        @(negedge clk); rx_eof = 1'b0; rx_crc_bad = 1'b0; rx_odd_bits = 1'b0;
    endtask

    task automatic send_strobe(input int kind);
        @(negedge clk);
        case (kind)
            0: rx_overrun = 1'b1;
            1: rx_carrier_lost = 1'b1;
            default: rx_clk_err = 1'b1;
        endcase
        @(negedge clk);
        rx_overrun = 1'b0; rx_carrier_lost = 1'b0; rx_clk_err = 1'b0;
    endtask

    task automatic hwrite(input int idx, input int sel, input int data);
        @(negedge clk);
        host_wr = 1'b1; host_idx = IW'(idx); host_sel = 2'(sel); host_wdata = 16'(data);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hcheck(input string req, input int idx, input int sel, input int exp);
        @(negedge clk);
        host_idx = IW'(idx); host_sel = 2'(sel);
        #1;
        chk(req, int'(host_rdata), exp);
    endtask

    task automatic settle(input string req);
        repeat (3) @(negedge clk);
        chk({req, " pending stores"}, exp_q.size(), 0);
    endtask

    task automatic one_byte_frame(input logic [7:0] d, input int addr);
        send_sof();
        send_char(d, 1'b0, addr);
        send_eof(1'b0, 1'b0);
    endtask

    initial begin
        int rxb0, busy0;
        rst_n = 1'b0;
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_par_err = 0; rx_crc_bad = 0;
        rx_odd_bits = 0; rx_overrun = 0; rx_carrier_lost = 0; rx_clk_err = 0;
        rx_data = '0; max_len = 16'd6;
        host_wr = 0; host_idx = '0; host_sel = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < ND; i++) begin
            hcheck("R1 status", i, 0, 0);
            hcheck("R1 length", i, 1, 0);
            hcheck("R1 pointer", i, 2, 0);
        end
        chk("R1 events", int'(evt_rxb) + int'(evt_busy) + int'(mem_we), 0);

        // R13: characters with no frame open are ignored
        cur_req = "R13";
        send_char(8'h11, 1'b0, -1);
        send_char(8'h12, 1'b0, -1);
        settle("R13");

        // program the ring: E|I, last one also W
        for (int i = 0; i < ND; i++) hwrite(i, 2, 16'h0100 * (i + 1));
        for (int i = 0; i < ND - 1; i++) hwrite(i, 0, 16'h9000);
        hwrite(ND - 1, 0, 16'hB000);

        // R4/R6/R7: simple frame into descriptor 0
        cur_req = "R4"; rxb0 = n_rxb;
        send_sof();
        send_char(8'hA0, 1'b0, 16'h0100);
        send_char(8'hA1, 1'b0, 16'h0101);
        send_char(8'hA2, 1'b0, 16'h0102);
        send_eof(1'b0, 1'b0);
        settle("R4");
        hcheck("R6 first+last status", 0, 0, 16'h1C00);
        hcheck("R4 length", 0, 1, 3);
        chk("R7 close event", n_rxb - rxb0, 1);

        // R11/R10: eight bytes split at limit 6, bad check at end
        cur_req = "R11"; rxb0 = n_rxb;
        send_sof();
        for (int k = 0; k < 6; k++) send_char(8'hB0 + 8'(k), 1'b0, 16'h0200 + k);
        for (int k = 0; k < 2; k++) send_char(8'hC0 + 8'(k), 1'b0, 16'h0300 + k);
        send_eof(1'b1, 1'b0);
        settle("R11");
        hcheck("R11 limit close no L", 1, 0, 16'h1400);
        hcheck("R11 limit length", 1, 1, 6);
        hcheck("R10 CR in last buffer, no F", 2, 0, 16'h1804);
        hcheck("R4 length second buffer", 2, 1, 2);
        chk("R7 two events", n_rxb - rxb0, 2);

        // R9/R5/R3: parity close in wrap descriptor, then busy at index 0
        cur_req = "R9"; rxb0 = n_rxb; busy0 = n_busy;
        send_sof();
        send_char(8'hD0, 1'b0, 16'h0400);
        send_char(8'hD1, 1'b1, 16'h0401);
        cur_req = "R3";
        send_char(8'hD2, 1'b0, -1);
        send_char(8'hD3, 1'b0, -1);
        send_eof(1'b0, 1'b0);
        settle("R3");
        hcheck("R9 parity close status", 3, 0, 16'h3408);
        hcheck("R9 parity close length", 3, 1, 2);
        chk("R3 busy event", n_busy - busy0, 1);
        chk("R7 parity close event", n_rxb - rxb0, 1);
        hcheck("R3 held descriptor untouched", 0, 0, 16'h1C00);

        // R8/R5: continuous mode at index 0 (index stayed at 0 after busy)
        cur_req = "R8";
        hwrite(0, 0, 16'h9200);
        send_sof();
        send_char(8'hE0, 1'b0, 16'h0100);
        send_char(8'hE1, 1'b0, 16'h0101);
        send_eof(1'b0, 1'b0);
        settle("R8");
        hcheck("R8 E kept in continuous mode", 0, 0, 16'h9E00);
        hcheck("R8 length", 0, 1, 2);

        // walk the ring back round to index 0
        cur_req = "R5";
        hwrite(1, 0, 16'h9000);
        hwrite(2, 0, 16'h9000);
        hwrite(3, 0, 16'hB000);
        one_byte_frame(8'hF1, 16'h0200);
        one_byte_frame(8'hF2, 16'h0300);
        one_byte_frame(8'hF3, 16'h0400);
        settle("R5");
        hcheck("R5 wrap descriptor status", 3, 0, 16'h3C00);

        // R8/R10: revisit continuous descriptor with an overrun
        cur_req = "R8";
        send_sof();
        send_strobe(0);
        send_char(8'hE7, 1'b0, 16'h0100);
        send_eof(1'b0, 1'b0);
        settle("R8");
        hcheck("R8 error clears E, R10 OV", 0, 0, 16'h1E02);
        hcheck("R8 overwrite length", 0, 1, 1);

        // R12/R10: deferred pointer write while filling descriptor 1
        cur_req = "R12";
        hwrite(1, 0, 16'h9000);
        send_sof();
        send_char(8'h51, 1'b0, 16'h0200);
        hwrite(1, 2, 16'h0A00);
        hcheck("R12 pointer unchanged while open", 1, 2, 16'h0200);
        send_strobe(1);
        send_char(8'h52, 1'b0, 16'h0201);
        send_strobe(2);
        send_eof(1'b0, 1'b1);
        settle("R12");
        hcheck("R10 CD DE NO status", 1, 0, 16'h1C91);
        hcheck("R12 pointer after close", 1, 2, 16'h0A00);
        hcheck("R4 length with errors", 1, 1, 2);

        // R2: reserved bits stay clear
        hwrite(2, 0, 16'hFFFF);
        hcheck("R2 reserved bits", 2, 0, 16'hBE9F);
        hwrite(2, 0, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule